// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block merges the four interrupt causes of a PC-style serial port into one identification value and one level interrupt line. The causes are a receive error on the line, received data waiting, an empty transmit holding register and a change on the modem status inputs. Neighbouring logic raises and lowers each cause through per-source set and clear pulses. This block holds the pending flags, the 4-bit enable register written from the host bus, and a fixed priority encoder.

The host reads the identification value to find the most urgent enabled cause. Reading it while it reports the transmit-empty cause acknowledges that cause and clears it. The interrupt line is a level signal. It is gated by an output bit of the modem control register, held outside this block and supplied as an input, so software can disconnect the port from the interrupt controller.

Top module: `uart_irq_encoder`

## Requirements
- R1: After reset the enable register is 0, all pending flags are clear, `iid_q` reads 0x01 and `irq` is low.
- R2: A write stores only `ier_wdata[3:0]`, with bit 0 enabling receive data, bit 1 transmit empty, bit 2 line status and bit 3 modem status. Bits 7:4 are dropped, so writing 0xF0 with every cause pending leaves `iid_q` at 0x01 and `irq` low.
- R3: A cause takes part in the encoding only while both its enable bit and its pending flag are 1.
- R4: When several causes are active, line status wins over receive data, receive data wins over transmit empty, and transmit empty wins over modem status.
- R5: `iid_q[3:0]` is 0x6 for line status, 0x4 for receive data, 0x2 for transmit empty and 0x0 for modem status.
- R6: With no active cause, `iid_q[3:0]` is 0x1: bit 0 high means no interrupt.
- R7: `iid_q[7:6]` is 2'b11 while `fifo_en` is 1 and 2'b00 otherwise. `iid_q[5:4]` is always 0.
- R8: `irq` is 1 exactly when some cause is active and `out2` is 1.
- R9: A cycle with `iid_rd` high while `iid_q[3:0]` is 0x2 clears the transmit-empty flag at that clock edge. A read that shows any other code leaves that flag unchanged.
- R10: The pending flags use the same bit order as the enable register. A `pend_set` bit sets its flag and a `pend_clr` bit clears it at the next edge. A set wins over any clear in the same cycle, including the clear caused by a read.
- R11: `iid_q` and `irq` follow `out2` and `fifo_en` combinationally. They reflect an enable write or a flag change from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| iid_rd | input | 1 | Read strobe of the identification register |
| fifo_en | input | 1 | FIFO enable bit of the FIFO control register |
| out2 | input | 1 | Interrupt gate bit of the modem control register |
| pend_set | input | 4 | Per-source set pulses from neighbouring logic |
| pend_clr | input | 4 | Per-source clear pulses from neighbouring logic |
| iid_q | output | 8 | Identification value |
| irq | output | 1 | Level interrupt request |

## Verification
An enable write, a set or clear pulse, or an acknowledging read shows on `iid_q` and `irq` from the clock edge that takes it, one register deep. A change on `out2` or `fifo_en` shows in the same cycle with no register in the path. The driver applies every stimulus on the falling edge and pushes the expected output for the state after the next rising edge. The monitor compares a quarter period after that rising edge, with inputs still stable, so both the registered and the combinational paths are sampled once they have settled. All 256 pairs of enable and pending values are swept, and `out2` and `fifo_en` are toggled along the way.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC   = 4;
   localparam int SRC_RX = 0;
   localparam int SRC_TX = 1;
   localparam int SRC_LS = 2;
   localparam int SRC_MS = 3;

   typedef enum logic [3:0] {
      ID_MS   = 4'h0,
      ID_NONE = 4'h1,
      ID_TX   = 4'h2,
      ID_RX   = 4'h4,
      ID_LS   = 4'h6
   } iid_code_e;
endpackage

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   if (N < 1) begin : g_bad_n
      $error("uart_irq_pend: N must be at least 1");
   end

   for (genvar k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend_o[k] <= 1'b0;
         else if (set_i[k])   pend_o[k] <= 1'b1;
         else if (clr_i[k])   pend_o[k] <= 1'b0;
      end

      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[k] |=> pend_o[k]);
      // R10
      clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic [NSRC-1:0] ier_i,
   input  logic [NSRC-1:0] pend_i,
   output iid_code_e       code_o,
   output logic            any_o
);
   logic [NSRC-1:0] act;

   assign act   = ier_i & pend_i;
   assign any_o = |act;

   always_comb begin
      if (act[SRC_LS])      code_o = ID_LS;
      else if (act[SRC_RX]) code_o = ID_RX;
      else if (act[SRC_TX]) code_o = ID_TX;
      else if (act[SRC_MS]) code_o = ID_MS;
      else                  code_o = ID_NONE;
   end
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
   import uart_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ier_wr,
   input  logic [DATA_W-1:0] ier_wdata,
   input  logic              iid_rd,
   input  logic              fifo_en,
   input  logic              out2,
   input  logic [NSRC-1:0]   pend_set,
   input  logic [NSRC-1:0]   pend_clr,
   output logic [DATA_W-1:0] iid_q,
   output logic              irq
);
   localparam int FLAG_LO = DATA_W - 2;

   if (DATA_W < 8) begin : g_bad_w
      $error("uart_irq_encoder: DATA_W must be at least 8");
   end

   logic [NSRC-1:0] ier_q;
   logic [NSRC-1:0] pend_q;
   logic [NSRC-1:0] clr_all;
   logic            tx_ack;
   logic            any_act;
   iid_code_e       code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ier_q <= '0;
      else if (ier_wr) ier_q <= ier_wdata[NSRC-1:0];
   end

   assign tx_ack  = iid_rd && (code == ID_TX);
   assign clr_all = pend_clr | (NSRC'(tx_ack) << SRC_TX);

   uart_irq_pend #(.N(NSRC)) i_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pend_set),
      .clr_i  (clr_all),
      .pend_o (pend_q)
   );

   uart_irq_prio i_prio (
      .ier_i  (ier_q),
      .pend_i (pend_q),
      .code_o (code),
      .any_o  (any_act)
   );

   always_comb begin
      iid_q                       = '0;
      iid_q[3:0]                  = code;
      iid_q[DATA_W-1:FLAG_LO]     = {2{fifo_en}};
   end

   assign irq = any_act && out2;

   // R2
   ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ier_wr |=> ier_q == $past(ier_wdata[NSRC-1:0]));
   // R8
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out2 |-> !irq);
   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iid_q[0] |-> !irq);
   // R9
   tx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd && iid_q[3:0] == 4'h2 && !pend_set[SRC_TX]) |=> iid_q[3:0] != 4'h2);
endmodule

// File: tb/test_uart_irq_encoder.sv
module test_uart_irq_encoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ier_wr = 1'b0;
   logic [7:0] ier_wdata = '0;
   logic       iid_rd = 1'b0;
   logic       fifo_en = 1'b0;
   logic       out2 = 1'b0;
   logic [3:0] pend_set = '0;
   logic [3:0] pend_clr = '0;
   logic [7:0] iid_q;
   logic       irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [3:0] m_ier = '0;
   logic [3:0] m_pend = '0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   uart_irq_encoder i_uart_irq_encoder (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .iid_rd(iid_rd), .fifo_en(fifo_en), .out2(out2),
      .pend_set(pend_set), .pend_clr(pend_clr), .iid_q(iid_q), .irq(irq)
   );

   function automatic logic [8:0] model(input logic [3:0] en, input logic [3:0] pd,
                                        input logic g, input logic f);
      logic [3:0] a;
      logic [3:0] c;
      a = en & pd;
      if (a[2])      c = 4'h6;
      else if (a[0]) c = 4'h4;
      else if (a[1]) c = 4'h2;
      else if (a[3]) c = 4'h0;
      else           c = 4'h1;
      return {{f, f, 2'b00, c}, (|a) & g};
   endfunction

   task automatic step(input logic wr, input logic [7:0] wd, input logic rd,
                       input logic [3:0] st, input logic [3:0] cl,
                       input logic g, input logic f, input string tag);
      logic [8:0] cur;
      logic [3:0] ack;
      @(negedge clk);
      ier_wr = wr; ier_wdata = wd; iid_rd = rd;
      pend_set = st; pend_clr = cl; out2 = g; fifo_en = f;
      cur = model(m_ier, m_pend, g, f);
      ack = (rd && cur[4:1] == 4'h2) ? 4'b0010 : 4'b0000;
      m_pend = (m_pend & ~cl & ~ack) | st;
      if (wr) m_ier = wd[3:0];
      exp_q.push_back(model(m_ier, m_pend, g, f));
      tag_q.push_back(tag);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if ({iid_q, irq} !== e) begin
               n_fail++;
               $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b",
                        t, iid_q, irq, e[8:1], e[0]);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      // R1: reset state
      step(0, 8'h00, 0, 4'h0, 4'h0, 1, 0, "R1 reset");
      // R2: upper enable bits dropped
      step(1, 8'hF0, 0, 4'hF, 4'h0, 1, 0, "R2 upper bits");
      step(1, 8'h08, 0, 4'h0, 4'h0, 1, 0, "R2 bit3 modem");
      // R3 R4 R5 R6 R8 R11: full sweep of enable x pending
      for (int e = 0; e < 16; e++) begin
         for (int p = 0; p < 16; p++) begin
            step(1, 8'(e), 0, 4'(p), 4'hF, logic'(p[0] ^ e[1]), logic'(e[2]),
                 "R3/R4/R5/R6/R8 sweep");
         end
      end
      // R11: out2 and fifo_en alone change outputs
      step(1, 8'h0F, 0, 4'hF, 4'h0, 0, 0, "R11 gate low");
      step(0, 8'h00, 0, 4'h0, 4'h0, 1, 0, "R11 gate high");
      // R7: fifo flag bits
      step(0, 8'h00, 0, 4'h0, 4'h0, 1, 1, "R7 fifo on");
      step(0, 8'h00, 0, 4'h0, 4'hF, 1, 1, "R7 fifo idle");
      // R9: read while tx shown clears it
      step(1, 8'h02, 0, 4'h2, 4'h0, 1, 0, "R9 tx shown");
      step(0, 8'h00, 1, 4'h0, 4'h0, 1, 0, "R9 ack clears");
      // R9: read while rx shown leaves tx
      step(1, 8'h03, 0, 4'h3, 4'h0, 1, 0, "R9 rx over tx");
      step(0, 8'h00, 1, 4'h0, 4'h0, 1, 0, "R9 rx read keeps tx");
      step(0, 8'h00, 0, 4'h0, 4'h1, 1, 0, "R9 tx remains");
      // R10: set wins over read clear and neighbour clear
      step(0, 8'h00, 1, 4'h2, 4'h0, 1, 0, "R10 set beats ack");
      step(0, 8'h00, 0, 4'h2, 4'h2, 1, 0, "R10 set beats clr");
      step(0, 8'h00, 0, 4'h0, 4'h2, 1, 0, "R10 clr alone");
      step(1, 8'h0F, 0, 4'h8, 4'h0, 1, 0, "R10 modem set");
      step(0, 8'h00, 0, 4'h0, 4'h0, 1, 0, "R10 idle hold");
      @(negedge clk);
      ier_wr = 0; iid_rd = 0; pend_set = '0; pend_clr = '0;
      repeat (2) @(posedge clk);
      #6;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule